// File: doc/BRIEF.md
# Flash Command Entry Sequencer

This block takes one serial-flash operation, described by a set of fields held at its inputs, and expands it into the ordered list of 20-bit command entries that a downstream executor runs one after another. An operation consists of a chip-select assert, an opcode, an address of up to four bytes, an optional dummy phase, an optional data phase, and a chip-select release. Each phase can use a lane width of its own.

A pulse on `start` while the block is idle captures the whole descriptor. From then on the block holds `busy` high and presents one entry at a time on a valid/ready stream, until the release entry has been accepted. The block lowers the data length into exponent entries, each covering a power-of-two block of 256 bytes or more, and ends with at most one plain entry for the remainder below 256. It also converts the dummy byte count into a count of dummy clocks. The block always addresses the lower bus with the lower chip select. It moves no payload itself.

Top module: `flash_cmd_seq`

## Requirements
- R1: The first entry after `start` is the chip-select assert, 0x05405. It has bit 14 (lower bus), bit 12 (lower chip select) and mode bits [11:10]=01 set, and an immediate [7:0] of 5. Bits 13, 15, 18 and 19 are zero in every entry.
- R2: The second entry is the opcode. It has bits 14 and 12, bit 16 (transmit), the mode for the opcode lane width, and the opcode in [7:0].
- R3: After the opcode come min(addrBytes, 4) address entries, most significant byte first. Each has bits 14, 12 and 16 set and the address lane mode. Byte i of n is the address shifted right by 8*(n-1-i). Counts above 4 count as 4.
- R4: When the dummy byte count is nonzero, one dummy entry follows. It has bits 14, 12 and 8 (data transfer) set, bits 16 and 17 clear, the dummy lane mode, and an immediate of dummyBytes*8 divided by the lane count of that mode (1, 2 or 4).
- R5: Mode bits [11:10] map lane width 1 to 01, 2 to 10 and 4 to 11. Any other width gives 01 with one lane.
- R6: While more than 255 bytes remain, the block emits a data entry with bit 9 (exponent) set and, as immediate, the position p of the lowest set bit at 8 or above. It then removes 2^p from the remaining count. A nonzero remainder of 255 or less gives one last entry with bit 9 clear and the remainder as immediate.
- R7: Data entries set bit 8 plus bit 16 when dataDir is 2'b10 (out) or bit 17 when dataDir is 2'b01 (in), and carry the data lane mode. dataDir 2'b00 or 2'b11, or a zero length, produces no data entries.
- R8: The last entry is the chip-select release, 0x04005: bit 14 only, with an immediate of 5.
- R9: An entry that is valid but not accepted stays valid and unchanged. `busy` rises the cycle after an idle `start` and falls the cycle after the release entry is accepted. `start` and descriptor changes while busy have no effect.
- R10: After reset `busy` and `entryValid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture descriptor and begin, honoured when idle |
| opcode | input | 8 | Command opcode |
| opWidth | input | 3 | Opcode lane width |
| addrBytes | input | $clog2(ADDR_W/8+1) | Address byte count |
| addrVal | input | ADDR_W | Address value |
| addrWidth | input | 3 | Address lane width |
| dummyBytes | input | 5 | Dummy byte count |
| dummyWidth | input | 3 | Dummy lane width |
| dataLen | input | LEN_W | Data byte count |
| dataDir | input | 2 | 01 in, 10 out, other none |
| dataWidth | input | 3 | Data lane width |
| busy | output | 1 | Operation in progress |
| entryValid | output | 1 | Entry presented |
| entryReady | input | 1 | Consumer accepts the entry |
| entry | output | 20 | Command entry |

## Verification
The bench builds the block with LEN_W set to 12. This lets it sweep every data length from 0 to 4095, so every pattern of exponent entries over bit positions 8 to 11 occurs, with and without a plain remainder. With the default 32-bit length that sweep would be out of reach. The bench also sweeps all eight lane-width codes on every phase, all address byte counts up to the clamp, and every dummy byte count. Some operations run under a stalling consumer, and one pokes `start` and the descriptor while the block is busy.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int ENTRY_W = 20;
  localparam int IMM_W   = 8;
  localparam int DUMMY_W = 5;
  localparam int CS_IMM  = 5;

  // entry bit positions decoded by the executor
  localparam int B_DATA   = 8;
  localparam int B_EXP    = 9;
  localparam int B_MODE   = 10;
  localparam int B_CS_LO  = 12;
  localparam int B_BUS_LO = 14;
  localparam int B_TX     = 16;
  localparam int B_RX     = 17;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CS_ON, PH_OPCODE, PH_ADDR, PH_DUMMY, PH_DATA, PH_CS_OFF
  } phase_t;

  typedef struct packed {
    logic   load;
    logic   addrStep;
    logic   dataStep;
    phase_t phase;
  } ctrl_strobe_t;

  typedef struct packed {
    logic hasAddr;
    logic addrLast;
    logic hasDummy;
    logic hasData;
    logic dataLast;
  } dp_status_t;

  function automatic logic [1:0] laneMode(input logic [2:0] w);
    case (w)
      3'd2:    return 2'b10;
      3'd4:    return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [1:0] laneShift(input logic [1:0] m);
    case (m)
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int LEN_W  = 32,
  parameter int ADDR_W = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctrl_strobe_t                       strobe,
  input  logic [7:0]                         opcode,
  input  logic [2:0]                         opWidth,
  input  logic [$clog2(ADDR_W/8+1)-1:0]      addrBytes,
  input  logic [ADDR_W-1:0]                  addrVal,
  input  logic [2:0]                         addrWidth,
  input  logic [DUMMY_W-1:0]                 dummyBytes,
  input  logic [2:0]                         dummyWidth,
  input  logic [LEN_W-1:0]                   dataLen,
  input  logic [1:0]                         dataDir,
  input  logic [2:0]                         dataWidth,
  output dp_status_t                         status,
  output logic [ENTRY_W-1:0]                 entry
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int ABC_W      = $clog2(ADDR_BYTES + 1);
  localparam int POS_W      = $clog2(LEN_W);

  logic [7:0]        opcodeQ;
  logic [1:0]        opModeQ, addrModeQ, dummyModeQ, dataModeQ;
  logic [ADDR_W-1:0] addrShQ;
  logic [ABC_W-1:0]  addrCntQ;
  logic [IMM_W-1:0]  dummyImmQ;
  logic              txDirQ;
  logic [LEN_W-1:0]  remQ;

  logic [ABC_W-1:0]  nBytes;
  logic [1:0]        dummyMode;
  logic [IMM_W-1:0]  dummyImm;
  logic [POS_W-1:0]  lowPos;
  logic              remBig;
  logic [LEN_W-1:0]  nextRem;

  assign nBytes    = (addrBytes > ABC_W'(ADDR_BYTES)) ? ABC_W'(ADDR_BYTES) : addrBytes;
  assign dummyMode = laneMode(dummyWidth);
  assign dummyImm  = IMM_W'({dummyBytes, 3'b000} >> laneShift(dummyMode));

  // lowest set bit at or above position 8
  always_comb begin
    lowPos = '0;
    for (int b = LEN_W - 1; b >= 8; b--) begin
      if (remQ[b]) lowPos = POS_W'(b);
    end
  end

  assign remBig  = |remQ[LEN_W-1:8];
  assign nextRem = remBig ? (remQ & ~(LEN_W'(1) << lowPos)) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeQ    <= '0;
      opModeQ    <= 2'b01;
      addrModeQ  <= 2'b01;
      dummyModeQ <= 2'b01;
      dataModeQ  <= 2'b01;
      addrShQ    <= '0;
      addrCntQ   <= '0;
      dummyImmQ  <= '0;
      txDirQ     <= 1'b0;
      remQ       <= '0;
    end else if (strobe.load) begin
      opcodeQ    <= opcode;
      opModeQ    <= laneMode(opWidth);
      addrModeQ  <= laneMode(addrWidth);
      dummyModeQ <= dummyMode;
      dataModeQ  <= laneMode(dataWidth);
      addrShQ    <= addrVal << (8 * (ADDR_BYTES - int'(nBytes)));
      addrCntQ   <= nBytes;
      dummyImmQ  <= dummyImm;
      txDirQ     <= (dataDir == 2'b10);
      remQ       <= (dataDir == 2'b01 || dataDir == 2'b10) ? dataLen : '0;
    end else begin
      if (strobe.addrStep) begin
        addrShQ  <= addrShQ << 8;
        addrCntQ <= addrCntQ - 1'b1;
      end
      if (strobe.dataStep) remQ <= nextRem;
    end
  end

  assign status.hasAddr  = (addrCntQ != '0);
  assign status.addrLast = (addrCntQ == ABC_W'(1));
  assign status.hasDummy = (dummyImmQ != '0);
  assign status.hasData  = (remQ != '0);
  assign status.dataLast = (nextRem == '0);

  always_comb begin
    entry = '0;
    if (strobe.phase != PH_IDLE) entry[B_BUS_LO] = 1'b1;
    case (strobe.phase)
      PH_CS_ON: begin
        entry[B_CS_LO]          = 1'b1;
        entry[B_MODE+:2]        = 2'b01;
        entry[IMM_W-1:0]        = IMM_W'(CS_IMM);
      end
      PH_OPCODE: begin
        entry[B_CS_LO]          = 1'b1;
        entry[B_TX]             = 1'b1;
        entry[B_MODE+:2]        = opModeQ;
        entry[IMM_W-1:0]        = opcodeQ;
      end
      PH_ADDR: begin
        entry[B_CS_LO]          = 1'b1;
        entry[B_TX]             = 1'b1;
        entry[B_MODE+:2]        = addrModeQ;
        entry[IMM_W-1:0]        = addrShQ[ADDR_W-1 -: 8];
      end
      PH_DUMMY: begin
        entry[B_CS_LO]          = 1'b1;
        entry[B_DATA]           = 1'b1;
        entry[B_MODE+:2]        = dummyModeQ;
        entry[IMM_W-1:0]        = dummyImmQ;
      end
      PH_DATA: begin
        entry[B_CS_LO]          = 1'b1;
        entry[B_DATA]           = 1'b1;
        entry[B_TX]             = txDirQ;
        entry[B_RX]             = !txDirQ;
        entry[B_MODE+:2]        = dataModeQ;
        entry[B_EXP]            = remBig;
        entry[IMM_W-1:0]        = remBig ? IMM_W'(lowPos) : remQ[IMM_W-1:0];
      end
      PH_CS_OFF: entry[IMM_W-1:0] = IMM_W'(CS_IMM);
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         entryReady,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         busy,
  output logic         entryValid
);
  phase_t state, nextState, afterAddr;
  logic   accept;

  assign entryValid = (state != PH_IDLE);
  assign busy       = entryValid;
  assign accept     = entryValid && entryReady;
  assign afterAddr  = status.hasDummy ? PH_DUMMY : (status.hasData ? PH_DATA : PH_CS_OFF);

  always_comb begin
    strobe.phase    = state;
    strobe.load     = start && (state == PH_IDLE);
    strobe.addrStep = accept && (state == PH_ADDR);
    strobe.dataStep = accept && (state == PH_DATA);
  end

  always_comb begin
    nextState = state;
    case (state)
      PH_IDLE:   if (start) nextState = PH_CS_ON;
      PH_CS_ON:  if (accept) nextState = PH_OPCODE;
      PH_OPCODE: if (accept) nextState = status.hasAddr ? PH_ADDR : afterAddr;
      PH_ADDR:   if (accept && status.addrLast) nextState = afterAddr;
      PH_DUMMY:  if (accept) nextState = status.hasData ? PH_DATA : PH_CS_OFF;
      PH_DATA:   if (accept && status.dataLast) nextState = PH_CS_OFF;
      PH_CS_OFF: if (accept) nextState = PH_IDLE;
      default:   nextState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int LEN_W  = 32,
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [7:0]                    opcode,
  input  logic [2:0]                    opWidth,
  input  logic [$clog2(ADDR_W/8+1)-1:0] addrBytes,
  input  logic [ADDR_W-1:0]             addrVal,
  input  logic [2:0]                    addrWidth,
  input  logic [4:0]                    dummyBytes,
  input  logic [2:0]                    dummyWidth,
  input  logic [LEN_W-1:0]              dataLen,
  input  logic [1:0]                    dataDir,
  input  logic [2:0]                    dataWidth,
  output logic                          busy,
  output logic                          entryValid,
  input  logic                          entryReady,
  output logic [19:0]                   entry
);
  ctrl_strobe_t strobe;
  dp_status_t   status;

  flash_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .entryReady(entryReady),
    .status(status), .strobe(strobe), .busy(busy), .entryValid(entryValid)
  );

  flash_cmd_dp #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opcode(opcode), .opWidth(opWidth),
    .addrBytes(addrBytes), .addrVal(addrVal), .addrWidth(addrWidth),
    .dummyBytes(dummyBytes), .dummyWidth(dummyWidth),
    .dataLen(dataLen), .dataDir(dataDir), .dataWidth(dataWidth),
    .status(status), .entry(entry)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int LEN_W = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        entryValid,
  input logic        entryReady,
  input logic [19:0] entry
);
  // R9: a stalled entry holds
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && !entryReady) |=> (entryValid && $stable(entry)));

  // R9: idle start begins an operation
  a_r9_start_begins: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  // R10: nothing presented while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !entryValid);

  // R1: operation opens with the chip-select assert entry
  a_r1_first_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (entry == 20'h05405));

  // R1: unused select and bus bits stay clear
  a_r1_unused_bits: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (entry[19:18] == 2'b00 && !entry[15] && !entry[13]));

  // R8: busy falls only after the release entry was taken
  a_r8_release_last: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(entryValid && entryReady && entry == 20'h04005));

  // R7: never transmit and receive together
  a_r7_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> !(entry[16] && entry[17]));

  // R6: exponent immediates lie inside the length field
  a_r6_exp_range: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && entry[9]) |-> (entry[7:0] >= 8'd8 && 32'(entry[7:0]) < LEN_W));
endmodule

bind flash_cmd_seq flash_cmd_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .entryValid(entryValid), .entryReady(entryReady), .entry(entry)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int LEN_W = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [2:0]  opWidth = 3'd1;
  logic [2:0]  addrBytes = '0;
  logic [31:0] addrVal = '0;
  logic [2:0]  addrWidth = 3'd1;
  logic [4:0]  dummyBytes = '0;
  logic [2:0]  dummyWidth = 3'd1;
  logic [LEN_W-1:0] dataLen = '0;
  logic [1:0]  dataDir = '0;
  logic [2:0]  dataWidth = 3'd1;
  logic        busy, entryValid;
  logic        entryReady = 1'b0;
  logic [19:0] entry;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [19:0] expE [0:63];
  string       expTag [0:63];
  int          expN;

  always #10 clk = ~clk;

  flash_cmd_seq #(.LEN_W(LEN_W), .ADDR_W(32)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .opWidth(opWidth),
    .addrBytes(addrBytes), .addrVal(addrVal), .addrWidth(addrWidth),
    .dummyBytes(dummyBytes), .dummyWidth(dummyWidth), .dataLen(dataLen),
    .dataDir(dataDir), .dataWidth(dataWidth), .busy(busy),
    .entryValid(entryValid), .entryReady(entryReady), .entry(entry)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int modeOf(input int w);
    if (w == 2) return 2;
    if (w == 4) return 3;
    return 1;
  endfunction

  function automatic int lanesOf(input int w);
    if (w == 2) return 2;
    if (w == 4) return 4;
    return 1;
  endfunction

  task automatic push(input int v, input string tag);
    expE[expN]   = 20'(v);
    expTag[expN] = tag;
    expN++;
  endtask

  task automatic runOp(input int opc, input int opW, input int aN, input int aV, input int aW,
                       input int dB, input int dW, input int len, input int dir, input int wD,
                       input bit stall, input bit poke);
    int base, na, rem, got, guard, p;
    base = (1 << 14) | (1 << 12);
    expN = 0;
    push(base | (1 << 10) | 5, "R1");
    push(base | (modeOf(opW) << 10) | (1 << 16) | (opc & 255), "R2");
    na = (aN > 4) ? 4 : aN;
    for (int i = 0; i < na; i++)
      push(base | (modeOf(aW) << 10) | (1 << 16) | ((aV >> (8 * (na - 1 - i))) & 255), "R3");
    if (dB != 0)
      push(base | (modeOf(dW) << 10) | (1 << 8) | ((dB * 8) / lanesOf(dW)), "R4");
    rem = (dir == 1 || dir == 2) ? len : 0;
    while (rem != 0) begin
      int e;
      e = base | (modeOf(wD) << 10) | (1 << 8) | ((dir == 2) ? (1 << 16) : (1 << 17));
      if (rem > 255) begin
        p = 0;
        for (int b = LEN_W - 1; b >= 8; b--) if (rem[b]) p = b;
        push(e | (1 << 9) | p, "R6");
        rem = rem - (1 << p);
      end else begin
        push(e | rem, "R7");
        rem = 0;
      end
    end
    push((1 << 14) | 5, "R8");

    opcode = 8'(opc); opWidth = 3'(opW); addrBytes = 3'(aN); addrVal = aV;
    addrWidth = 3'(aW); dummyBytes = 5'(dB); dummyWidth = 3'(dW);
    dataLen = LEN_W'(len); dataDir = 2'(dir); dataWidth = 3'(wD);
    start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R9 busy after start", 32'(busy), 1);
    if (poke) begin
      opcode = ~opcode; addrVal = ~addrVal; dataLen = ~dataLen; dummyBytes = ~dummyBytes;
    end else start = 1'b0;
    got = 0;
    guard = 0;
    while (1) begin
      entryReady = stall ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      #1;
      if (entryValid && entryReady) begin
        if (got < expN) check(entry == expE[got], expTag[got], 32'(entry), 32'(expE[got]));
        else check(1'b0, "R8 extra entry", 32'(entry), 0);
        got++;
      end
      @(negedge clk);
      guard++;
      if (!busy || guard > 200) break;
    end
    start = 1'b0;
    entryReady = 1'b0;
    check(got == expN, poke ? "R9 start ignored while busy" : "R8 entry count", got, expN);
    check(!entryValid, "R10 idle after operation", 32'(entryValid), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R10 busy at reset", 32'(busy), 0);
    check(entryValid == 1'b0, "R10 valid at reset", 32'(entryValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // typical quad read with three address bytes and dummy
    runOp(8'h6B, 1, 3, 32'h00123456, 1, 1, 4, 16, 1, 4, 0, 0);
    // four-byte address page write under a stalling consumer
    runOp(8'h12, 1, 4, 32'hA1B2C3D4, 2, 0, 1, 300, 2, 2, 1, 0);
    // R5: every lane-width code on every phase
    for (int w = 0; w < 8; w++) runOp(8'h3C, w, 2, 32'h0000BEEF, w, 3, w, 40, 1, w, w[0], 0);
    // R3: address byte counts including clamp
    for (int n = 0; n < 8; n++) runOp(8'h03, 1, n, 32'h89ABCDEF, 1, 0, 1, 0, 0, 1, 0, 0);
    // R4: every dummy byte count with each lane count
    for (int d = 0; d < 32; d++) runOp(8'hEB, 4, 0, 0, 1, d, (d % 3 == 0) ? 1 : ((d % 3 == 1) ? 2 : 4), 0, 0, 1, 0, 0);
    // R7: no data phase for direction codes 00 and 11
    runOp(8'h06, 1, 0, 0, 1, 0, 1, 100, 0, 1, 0, 0);
    runOp(8'h06, 1, 0, 0, 1, 0, 1, 100, 3, 1, 1, 0);
    // R9: start and descriptor changes while busy
    runOp(8'h9F, 1, 1, 32'h5A, 1, 2, 2, 777, 1, 2, 1, 1);
    // R6: exhaustive length sweep
    for (int L = 0; L < 4096; L++)
      runOp(8'h0B, 1, 0, 0, 1, 0, 1, L, (L % 2 == 1) ? 1 : 2, L % 5, (L % 4) == 3, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule